// File: doc/BRIEF.md
# Load-Use Stall and Bypass Select Unit

This unit sits beside the decode and execute stages of a five-stage in-order pipeline. It handles the one data dependency that bypassing cannot cover. A load that is in execute has its data only at the end of the following memory-access cycle. An instruction directly behind the load needs that data at the start of its own execute cycle, which is too early. When the unit sees this pairing, it freezes the program counter and the fetch/decode register for one cycle. In the same cycle it makes the decode/execute register take a bubble, which is an entry with every control write-enable cleared. The dependent instruction therefore reaches execute one cycle later, and the instructions behind it slip by one cycle.

For every other dependency the unit returns a bypass select for each source operand of the instruction now in execute. A matching memory-stage result takes priority over a matching writeback-stage result. A consumer two or more slots behind a load therefore needs no stall, because the forwarded value reaches it in time.

A saturating counter counts the bubbles inserted, so that the cost in cycles per instruction can be measured.

Top module: `hazard_guard`

## Requirements
- R1: `insert_bubble` and `hold_front` are both 1 in a cycle exactly when all of the following hold: `ex_is_load` is 1, `ex_dst_idx` is nonzero, the unit inserted no bubble in the previous cycle, and some source i has `id_src_used[i]`=1 and `id_src_idx[i*AW +: AW]` equal to `ex_dst_idx`. In every other cycle both outputs are 0.
- R2: A load whose destination is register 0 never causes a stall, whatever the source indices are.
- R3: A source whose use flag is 0 never causes a stall, even when its index equals the load destination.
- R4: In the cycle right after a bubble, the execute-stage inputs are treated as empty. A stall therefore never lasts more than one cycle.
- R5: A non-load instruction in execute never causes a stall, because forwarding covers it.
- R6: `idex_ctl_we` is all zeros while `insert_bubble` is 1. Otherwise it equals `id_ctl_we`.
- R7: The select for source i, at `fwd_sel[2i+1:2i]`, is 2'b01 (memory stage) when `mem_reg_we` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals execute source i. This holds even when the writeback stage also matches.
- R8: The select is 2'b10 (writeback stage) when `wb_reg_we` is 1, `wb_dst_idx` is nonzero and equals execute source i, and the memory stage does not match as described in R7.
- R9: The select is 2'b00 (register file) when neither stage matches. This includes every source index of 0.
- R10: `stall_count` rises by one at each clock edge where `insert_bubble` is 1. It holds at all ones once it reaches that value, and it does not change on other edges.
- R11: A synchronous active-high `rst` clears `stall_count` to 0 and clears the memory of a previous bubble. A stall can therefore fire in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_idx | input | NUM_SRC*AW | Register indices of the sources of the decode-stage instruction, source i at bits [i*AW +: AW] |
| id_src_used | input | NUM_SRC | Read flag for each decode-stage source |
| id_ctl_we | input | CTL_W | Control write-enables of the decode-stage instruction |
| ex_dst_idx | input | AW | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | The execute-stage instruction is a load |
| ex_src_idx | input | NUM_SRC*AW | Register indices of the sources of the execute-stage instruction |
| mem_dst_idx | input | AW | Destination register of the memory-stage instruction |
| mem_reg_we | input | 1 | The memory-stage instruction writes a register |
| wb_dst_idx | input | AW | Destination register of the writeback-stage instruction |
| wb_reg_we | input | 1 | The writeback-stage instruction writes a register |
| hold_front | output | 1 | Hold for the PC and the fetch/decode register |
| insert_bubble | output | 1 | Load a bubble into the decode/execute register |
| idex_ctl_we | output | CTL_W | Write-enables to capture into the decode/execute register |
| fwd_sel | output | 2*NUM_SRC | Bypass select per execute source: 00 register file, 01 memory stage, 10 writeback stage |
| stall_count | output | CNT_W | Saturating count of inserted bubbles |

## Verification
The bench builds the unit with three source operands, four-bit register indices, a two-bit write-enable field and a three-bit counter. The third source shows that stall detection and bypass selection work for every generated operand, not only the first two. The small index width means random traffic hits matching indices and register 0 often. The three-bit counter reaches saturation after seven bubbles, so the hold at all ones is exercised well inside a short run.

// File: rtl/hzg_pkg.sv
package hzg_pkg;

    localparam int MAX_AW = 16;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_src_e;

    typedef struct packed {
        logic hit_mem;
        logic hit_wb;
    } fwd_hits_t;

    // A writer that targets a live (nonzero) register with the same index
    function automatic logic live_match(input logic we,
                                        input logic [MAX_AW-1:0] dst,
                                        input logic [MAX_AW-1:0] src);
        return we && (dst != '0) && (dst == src);
    endfunction

    function automatic fwd_src_e pick_src(input fwd_hits_t h);
        if (h.hit_mem)     return FWD_MEM;
        else if (h.hit_wb) return FWD_WB;
        else               return FWD_RF;
    endfunction

endpackage

// File: rtl/hzg_load_use_det.sv
module hzg_load_use_det
    import hzg_pkg::*;
#(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*AW-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]    id_src_used,
    input  logic [AW-1:0]         ex_dst_idx,
    input  logic                  ex_is_load,
    input  logic                  ex_empty,
    output logic                  hazard
);

    logic [NUM_SRC-1:0] src_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = live_match(id_src_used[i],
                                       MAX_AW'(ex_dst_idx),
                                       MAX_AW'(id_src_idx[i*AW +: AW]));
    end

    assign hazard = ex_is_load && !ex_empty && (|src_hit);

endmodule

// File: rtl/hzg_fwd_sel.sv
module hzg_fwd_sel
    import hzg_pkg::*;
#(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*AW-1:0] ex_src_idx,
    input  logic [AW-1:0]         mem_dst_idx,
    input  logic                  mem_reg_we,
    input  logic [AW-1:0]         wb_dst_idx,
    input  logic                  wb_reg_we,
    output logic [2*NUM_SRC-1:0]  fwd_sel
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
        fwd_hits_t hits;
        fwd_src_e  choice;

        assign hits.hit_mem = live_match(mem_reg_we, MAX_AW'(mem_dst_idx),
                                         MAX_AW'(ex_src_idx[i*AW +: AW]));
        assign hits.hit_wb  = live_match(wb_reg_we, MAX_AW'(wb_dst_idx),
                                         MAX_AW'(ex_src_idx[i*AW +: AW]));
        assign choice = pick_src(hits);
        assign fwd_sel[2*i +: 2] = choice;
    end

endmodule

// File: rtl/hzg_stall_track.sv
module hzg_stall_track #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bubble,
    output logic             after_bubble,
    output logic [CNT_W-1:0] stall_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            after_bubble <= 1'b0;
            stall_count  <= '0;
        end else begin
            after_bubble <= bubble;
            if (bubble && (stall_count != CNT_MAX))
                stall_count <= stall_count + 1'b1;
        end
    end

endmodule

// File: rtl/hazard_guard.sv
module hazard_guard
    import hzg_pkg::*;
#(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2,
    parameter int CTL_W   = 3,
    parameter int CNT_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC*AW-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]    id_src_used,
    input  logic [CTL_W-1:0]      id_ctl_we,
    input  logic [AW-1:0]         ex_dst_idx,
    input  logic                  ex_is_load,
    input  logic [NUM_SRC*AW-1:0] ex_src_idx,
    input  logic [AW-1:0]         mem_dst_idx,
    input  logic                  mem_reg_we,
    input  logic [AW-1:0]         wb_dst_idx,
    input  logic                  wb_reg_we,
    output logic                  hold_front,
    output logic                  insert_bubble,
    output logic [CTL_W-1:0]      idex_ctl_we,
    output logic [2*NUM_SRC-1:0]  fwd_sel,
    output logic [CNT_W-1:0]      stall_count
);

    logic hazard;
    logic after_bubble;

    hzg_load_use_det #(.AW(AW), .NUM_SRC(NUM_SRC)) u_det (
        .id_src_idx  (id_src_idx),
        .id_src_used (id_src_used),
        .ex_dst_idx  (ex_dst_idx),
        .ex_is_load  (ex_is_load),
        .ex_empty    (after_bubble),
        .hazard      (hazard)
    );

    hzg_fwd_sel #(.AW(AW), .NUM_SRC(NUM_SRC)) u_fwd (
        .ex_src_idx  (ex_src_idx),
        .mem_dst_idx (mem_dst_idx),
        .mem_reg_we  (mem_reg_we),
        .wb_dst_idx  (wb_dst_idx),
        .wb_reg_we   (wb_reg_we),
        .fwd_sel     (fwd_sel)
    );

    hzg_stall_track #(.CNT_W(CNT_W)) u_trk (
        .clk          (clk),
        .rst          (rst),
        .bubble       (hazard),
        .after_bubble (after_bubble),
        .stall_count  (stall_count)
    );

    assign hold_front    = hazard;
    assign insert_bubble = hazard;
    assign idex_ctl_we   = hazard ? '0 : id_ctl_we;

endmodule

// File: rtl/hazard_guard_chk.sv
module hazard_guard_chk #(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2,
    parameter int CTL_W   = 3,
    parameter int CNT_W   = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [AW-1:0]         ex_dst_idx,
    input logic                  ex_is_load,
    input logic [NUM_SRC*AW-1:0] ex_src_idx,
    input logic [AW-1:0]         mem_dst_idx,
    input logic                  mem_reg_we,
    input logic                  insert_bubble,
    input logic [CTL_W-1:0]      idex_ctl_we,
    input logic [2*NUM_SRC-1:0]  fwd_sel,
    input logic [CNT_W-1:0]      stall_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R4
    single_stall_chk: assert property (@(posedge clk) disable iff (rst)
        insert_bubble |=> !insert_bubble);

    // R2
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_dst_idx == '0) |-> !insert_bubble);

    // R5
    nonload_chk: assert property (@(posedge clk) disable iff (rst)
        !ex_is_load |-> !insert_bubble);

    // R6
    bubble_clears_we_chk: assert property (@(posedge clk) disable iff (rst)
        insert_bubble |-> (idex_ctl_we == '0));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (insert_bubble && stall_count != CNT_MAX) |=>
            (stall_count == CNT_W'($past(stall_count) + 1'b1)));

    // R10
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!insert_bubble || stall_count == CNT_MAX) |=> $stable(stall_count));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
        // R7
        mem_priority_chk: assert property (@(posedge clk) disable iff (rst)
            (mem_reg_we && mem_dst_idx != '0 &&
             mem_dst_idx == ex_src_idx[i*AW +: AW]) |-> (fwd_sel[2*i +: 2] == 2'b01));
    end

endmodule

bind hazard_guard hazard_guard_chk #(
    .AW(AW), .NUM_SRC(NUM_SRC), .CTL_W(CTL_W), .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_dst_idx    (ex_dst_idx),
    .ex_is_load    (ex_is_load),
    .ex_src_idx    (ex_src_idx),
    .mem_dst_idx   (mem_dst_idx),
    .mem_reg_we    (mem_reg_we),
    .insert_bubble (insert_bubble),
    .idex_ctl_we   (idex_ctl_we),
    .fwd_sel       (fwd_sel),
    .stall_count   (stall_count)
);

// File: tb/sim_hazard_guard.sv
`timescale 1ns/1ps
module sim_hazard_guard;

    localparam int AW    = 4;
    localparam int NS    = 3;
    localparam int CTW   = 2;
    localparam int CW    = 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS*AW-1:0]  id_src_idx = '0;
    logic [NS-1:0]     id_src_used = '0;
    logic [CTW-1:0]    id_ctl_we = '0;
    logic [AW-1:0]     ex_dst_idx = '0;
    logic              ex_is_load = 1'b0;
    logic [NS*AW-1:0]  ex_src_idx = '0;
    logic [AW-1:0]     mem_dst_idx = '0;
    logic              mem_reg_we = 1'b0;
    logic [AW-1:0]     wb_dst_idx = '0;
    logic              wb_reg_we = 1'b0;
    logic              hold_front;
    logic              insert_bubble;
    logic [CTW-1:0]    idex_ctl_we;
    logic [2*NS-1:0]   fwd_sel;
    logic [CW-1:0]     stall_count;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  m_after = 0;
    int  m_cnt = 0;

    always #5 clk = ~clk;

    hazard_guard #(.AW(AW), .NUM_SRC(NS), .CTL_W(CTW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst),
        .id_src_idx(id_src_idx), .id_src_used(id_src_used), .id_ctl_we(id_ctl_we),
        .ex_dst_idx(ex_dst_idx), .ex_is_load(ex_is_load), .ex_src_idx(ex_src_idx),
        .mem_dst_idx(mem_dst_idx), .mem_reg_we(mem_reg_we),
        .wb_dst_idx(wb_dst_idx), .wb_reg_we(wb_reg_we),
        .hold_front(hold_front), .insert_bubble(insert_bubble),
        .idex_ctl_we(idex_ctl_we), .fwd_sel(fwd_sel), .stall_count(stall_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare at the falling edge, then advance the model at the rising edge
    task automatic tick(input string tag);
        bit exp_b;
        int exp_we;
        int exp_f;
        exp_b = 0;
        @(negedge clk);
        if (ex_is_load && ex_dst_idx != 0 && !m_after)
            for (int i = 0; i < NS; i++)
                if (id_src_used[i] && id_src_idx[i*AW +: AW] == ex_dst_idx) exp_b = 1;
        exp_we = exp_b ? 0 : int'(id_ctl_we);
        exp_f = 0;
        for (int i = 0; i < NS; i++) begin
            int s;
            s = int'(ex_src_idx[i*AW +: AW]);
            if (mem_reg_we && mem_dst_idx != 0 && int'(mem_dst_idx) == s)
                exp_f += 1 << (2*i);
            else if (wb_reg_we && wb_dst_idx != 0 && int'(wb_dst_idx) == s)
                exp_f += 2 << (2*i);
        end
        check({tag, " hold"}, int'(hold_front), int'(exp_b));
        check({tag, " bubble"}, int'(insert_bubble), int'(exp_b));
        check("R6 idex_ctl_we", int'(idex_ctl_we), exp_we);
        check("R7 R8 R9 fwd_sel", int'(fwd_sel), exp_f);
        check("R10 R11 stall_count", int'(stall_count), m_cnt);
        @(posedge clk);
        if (rst) begin
            m_after = 0;
            m_cnt = 0;
        end else begin
            m_after = exp_b;
            if (exp_b && m_cnt != CMAX) m_cnt++;
        end
        #1;
    endtask

    task automatic set_id(input int s0, input int s1, input int s2, input int used);
        id_src_idx[0*AW +: AW] = AW'(s0);
        id_src_idx[1*AW +: AW] = AW'(s1);
        id_src_idx[2*AW +: AW] = AW'(s2);
        id_src_used = NS'(used);
    endtask

    task automatic set_ex(input int dst, input bit ld);
        ex_dst_idx = AW'(dst);
        ex_is_load = ld;
    endtask

    initial begin
        @(posedge clk); #1;
        tick("R11 reset");
        tick("R11 reset");
        rst = 1'b0;
        id_ctl_we = 2'b11;

        // R1 / R11: load r3 then a consumer of r3 in the first cycle after reset
        set_ex(3, 1); set_id(3, 5, 6, 3'b001);
        tick("R1 R11 first stall");
        set_ex(0, 0);                       // bubble now in execute
        tick("R1 after bubble");

        // R4: execute inputs still claim the load right after a bubble
        set_ex(7, 1); set_id(1, 7, 2, 3'b010);
        tick("R1 stall");
        tick("R4 suppressed");
        tick("R1 stall again");

        // R2: destination 0
        set_ex(0, 1); set_id(0, 0, 0, 3'b111);
        tick("R2 zero dst");

        // R3: matching source not read; then third source read and matching
        set_ex(9, 1); set_id(9, 9, 4, 3'b100);
        tick("R3 unused src");
        set_id(1, 2, 9, 3'b100);
        tick("R1 third source");
        set_ex(0, 0);
        tick("R1 idle");

        // R5: non-load producer
        set_ex(5, 0); set_id(5, 5, 5, 3'b111);
        tick("R5 non-load");

        // R7 R8 R9: bypass selects
        ex_src_idx[0*AW +: AW] = 4'd6;
        ex_src_idx[1*AW +: AW] = 4'd8;
        ex_src_idx[2*AW +: AW] = 4'd0;
        mem_dst_idx = 4'd6; mem_reg_we = 1;
        wb_dst_idx  = 4'd6; wb_reg_we  = 1;
        tick("R7 mem over wb");
        wb_dst_idx = 4'd8;
        tick("R8 wb only");
        mem_reg_we = 0; wb_dst_idx = 4'd6;
        tick("R8 mem disabled");
        mem_dst_idx = 4'd0; mem_reg_we = 1; wb_dst_idx = 4'd0;
        tick("R9 index zero");

        // R10: saturate the counter
        for (int k = 0; k < 10; k++) begin
            set_ex(2, 1); set_id(2, 0, 0, 3'b001);
            tick("R10 stall");
            set_ex(0, 0);
            tick("R10 gap");
        end

        // R11: reset mid-run
        rst = 1'b1;
        tick("R11 reset hold");
        rst = 1'b0;
        tick("R11 after reset");

        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            id_src_idx  = NS*AW'($urandom) & {NS{4'b0011}};
            id_src_used = NS'($urandom);
            id_ctl_we   = CTW'($urandom);
            ex_dst_idx  = AW'($urandom_range(0, 3));
            ex_is_load  = 1'($urandom);
            ex_src_idx  = NS*AW'($urandom) & {NS{4'b0011}};
            mem_dst_idx = AW'($urandom_range(0, 3));
            mem_reg_we  = 1'($urandom);
            wb_dst_idx  = AW'($urandom_range(0, 3));
            wb_reg_we   = 1'($urandom);
            tick("R1 R2 R3 R4 R5 mixed");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule